// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer. It divides a fast input clock by N = B·P + A. A dual-modulus prescaler divides by P or by P+1. A swallow count A and a main count B together set how many prescaler periods run at each modulus. Each output period starts with A prescaler periods of P+1 input cycles each. The remaining B−A prescaler periods are P input cycles each. A single-cycle pulse marks the end of the period, and both counts then reload.

The prescaler is ordinary synchronous logic clocked by the input. Its core divides by 4 or 5. An extension counter runs that core P/4 times and stretches only the last core pass when the swallow count is still non-zero. A settings word (prescaler mode, B, A) is presented with a load strobe. Each word is checked for legality when it arrives. A legal word is held in a pending stage and takes effect only at the next period boundary, or at once if the divider is still idle. An illegal word raises an error flag and leaves every setting in use unchanged.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While running, consecutive `div_o` pulses are exactly N = B·P + A input clock cycles apart.
- R2: `pmode_i` encodes the base modulus: 2'b00 gives P=8, 2'b01 gives P=16, 2'b10 gives P=32, and 2'b11 is illegal and rejected.
- R3: In every output period, `mod_ctl_o` is high for exactly A·(P+1) input cycles, starting with the first cycle of the period.
- R4: `div_o` is high for exactly one input cycle per output period.
- R5: A load with B < 3, A > B, an illegal mode, or N < P² − P sets `cfg_error_o` in the cycle after the strobe, and the divider keeps its previous N.
- R6: A legal load clears `cfg_error_o`. `cfg_valid_o` goes high once the first legal settings are in use.
- R7: A legal load made in the middle of an output period does not change that period; the new N applies from the next period.
- R8: After reset every output is low, and no pulse appears until a legal load has been made.
- R9: The limit is inclusive: N = P² − P is accepted, while any smaller N is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| pmode_i | input | 2 | Prescaler base modulus select |
| b_i | input | 13 | Main count B |
| a_i | input | 5 | Swallow count A |
| load_i | input | 1 | Strobe that presents a new settings word |
| div_o | output | 1 | Single-cycle pulse once per N input cycles |
| mod_ctl_o | output | 1 | High while the prescaler divides by P+1 |
| cfg_valid_o | output | 1 | Legal settings are in use and the divider runs |
| cfg_error_o | output | 1 | Last settings word was rejected |

## Verification
At P=8 the bench sweeps every B from 2 to 14 against every A from 0 to 31. This covers each legal pair and each rejection reason. For every legal pair it measures both the pulse spacing and the high time of the modulus control. Matching spacing alone could hide an error that trades long prescaler periods for short ones, so the high time separates a correct A/B split from such a compensating one. At P=16 and P=32, selected pairs check three cases: A=0 with mod_ctl never high, A=B with mod_ctl always high, and N exactly on the contiguity limit next to one step below it. A load placed mid-period, and illegal loads made while running, show that the period in progress and the divisor already in use both stay intact.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [1:0] {
        MODE_P8  = 2'b00,
        MODE_P16 = 2'b01,
        MODE_P32 = 2'b10,
        MODE_BAD = 2'b11
    } pmode_e;

    // Base modulus P for a mode; zero for the illegal code.
    function automatic logic [5:0] base_modulus(pmode_e m);
        case (m)
            MODE_P8:  return 6'd8;
            MODE_P16: return 6'd16;
            MODE_P32: return 6'd32;
            default:  return 6'd0;
        endcase
    endfunction

    // Last index of the extension counter: P/4 core passes per prescaler period.
    function automatic logic [2:0] ext_last(pmode_e m);
        case (m)
            MODE_P8:  return 3'd1;
            MODE_P16: return 3'd3;
            MODE_P32: return 3'd7;
            default:  return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/psd_cfg_check.sv
module psd_cfg_check
    import psd_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 5
) (
    input  pmode_e         mode_i,
    input  logic [B_W-1:0] b_i,
    input  logic [A_W-1:0] a_i,
    output logic           ok_o
);
    localparam int N_W = B_W + 7;

    logic [N_W-1:0] p_w;
    logic [N_W-1:0] n_w;
    logic [N_W-1:0] lim_w;

    always_comb begin
        p_w   = N_W'(base_modulus(mode_i));
        n_w   = N_W'(b_i) * p_w + N_W'(a_i);
        lim_w = p_w * p_w - p_w;
        ok_o  = (mode_i != MODE_BAD)
             && (b_i >= B_W'(3))
             && (B_W'(a_i) <= b_i)
             && (n_w >= lim_w);
    end

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_i,
    input  pmode_e mode_i,
    input  logic   swallow_i,
    output logic   wrap_o
);
    typedef struct packed {
        logic [2:0] core;
        logic [2:0] ext;
    } pre_t;

    pre_t st_d, st_q;
    logic [2:0] core_last;
    logic       ext_end;

    always_comb begin
        st_d      = st_q;
        ext_end   = (st_q.ext == ext_last(mode_i));
        // The 4/5 core stretches to 5 only on the last pass of a swallow period.
        core_last = (swallow_i && ext_end) ? 3'd4 : 3'd3;
        wrap_o    = run_i && (st_q.core == core_last) && ext_end;
        if (!run_i) begin
            st_d = '0;
        end else if (st_q.core == core_last) begin
            st_d.core = 3'd0;
            st_d.ext  = ext_end ? 3'd0 : st_q.ext + 3'd1;
        end else begin
            st_d.core = st_q.core + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a five-cycle core pass happens only while swallowing.
    a_r3_long_pass_only_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.core == 3'd4) |-> $past(swallow_i));

    // R2: the core never exceeds its longest length.
    a_r2_core_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.core <= 3'd4);

endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
    import psd_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           cfg_ok_i,
    input  pmode_e         pmode_i,
    input  logic [B_W-1:0] b_i,
    input  logic [A_W-1:0] a_i,
    input  logic           wrap_i,
    output logic           run_o,
    output pmode_e         act_mode_o,
    output logic           swallow_o,
    output logic           div_o,
    output logic           err_o
);
    typedef struct packed {
        logic           run;
        logic           err;
        logic           pend;
        logic           div;
        pmode_e         pend_mode;
        logic [B_W-1:0] pend_b;
        logic [A_W-1:0] pend_a;
        pmode_e         act_mode;
        logic [B_W-1:0] act_b;
        logic [A_W-1:0] act_a;
        logic [B_W-1:0] b_cnt;
        logic [A_W-1:0] a_cnt;
    } ctl_t;

    ctl_t st_d, st_q;
    logic period_end;

    always_comb begin
        st_d       = st_q;
        st_d.div   = 1'b0;
        period_end = st_q.run && wrap_i && (st_q.b_cnt == B_W'(1));

        if (!st_q.run) begin
            if (st_q.pend) begin
                st_d.run      = 1'b1;
                st_d.pend     = 1'b0;
                st_d.act_mode = st_q.pend_mode;
                st_d.act_b    = st_q.pend_b;
                st_d.act_a    = st_q.pend_a;
                st_d.b_cnt    = st_q.pend_b;
                st_d.a_cnt    = st_q.pend_a;
            end
        end else if (period_end) begin
            st_d.div = 1'b1;
            if (st_q.pend) begin
                st_d.pend     = 1'b0;
                st_d.act_mode = st_q.pend_mode;
                st_d.act_b    = st_q.pend_b;
                st_d.act_a    = st_q.pend_a;
                st_d.b_cnt    = st_q.pend_b;
                st_d.a_cnt    = st_q.pend_a;
            end else begin
                st_d.b_cnt = st_q.act_b;
                st_d.a_cnt = st_q.act_a;
            end
        end else if (wrap_i) begin
            st_d.b_cnt = st_q.b_cnt - B_W'(1);
            if (st_q.a_cnt != '0) st_d.a_cnt = st_q.a_cnt - A_W'(1);
        end

        if (load_i) begin
            if (cfg_ok_i) begin
                st_d.pend      = 1'b1;
                st_d.pend_mode = pmode_i;
                st_d.pend_b    = b_i;
                st_d.pend_a    = a_i;
                st_d.err       = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.pend_mode <= MODE_P8;
            st_q.act_mode  <= MODE_P8;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o      = st_q.run;
    assign act_mode_o = st_q.act_mode;
    assign swallow_o  = st_q.run && (st_q.a_cnt != '0);
    assign div_o      = st_q.div;
    assign err_o      = st_q.err;

    // R4: the divided pulse lasts a single cycle.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.div |=> !st_q.div);

    // R1: swallow count never exceeds the remaining main count.
    a_r1_swallow_le_main: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (B_W'(st_q.a_cnt) <= st_q.b_cnt));

    // R1: main count never sits at zero while running.
    a_r1_main_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.b_cnt != '0));

    // R7: settings in use change only at a period boundary or at start.
    a_r7_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.act_b) |-> (st_q.div || $rose(st_q.run)));

    // R3: modulus control can only begin at the start of a period.
    a_r3_swallow_starts_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swallow_o) |-> (st_q.div || $rose(st_q.run)));

    // R5: a rejected word leaves the pending settings untouched.
    a_r5_reject_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !cfg_ok_i) |=> $stable(st_q.pend_b));

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
    import psd_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     pmode_i,
    input  logic [B_W-1:0] b_i,
    input  logic [A_W-1:0] a_i,
    input  logic           load_i,
    output logic           div_o,
    output logic           mod_ctl_o,
    output logic           cfg_valid_o,
    output logic           cfg_error_o
);
    pmode_e mode_in;
    pmode_e act_mode;
    logic   cfg_ok;
    logic   wrap;
    logic   run;
    logic   swallow;

    assign mode_in = pmode_e'(pmode_i);

    psd_cfg_check #(.B_W(B_W), .A_W(A_W)) u_check (
        .mode_i (mode_in),
        .b_i    (b_i),
        .a_i    (a_i),
        .ok_o   (cfg_ok)
    );

    psd_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .mode_i    (act_mode),
        .swallow_i (swallow),
        .wrap_o    (wrap)
    );

    psd_swallow_ctrl #(.B_W(B_W), .A_W(A_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .cfg_ok_i   (cfg_ok),
        .pmode_i    (mode_in),
        .b_i        (b_i),
        .a_i        (a_i),
        .wrap_i     (wrap),
        .run_o      (run),
        .act_mode_o (act_mode),
        .swallow_o  (swallow),
        .div_o      (div_o),
        .err_o      (cfg_error_o)
    );

    assign mod_ctl_o   = swallow;
    assign cfg_valid_o = run;

    // R8: no pulse and no modulus control before settings are in use.
    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!div_o && !mod_ctl_o));

endmodule

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pmode_i = 2'b00;
    logic [12:0] b_i = '0;
    logic [4:0]  a_i = '0;
    logic        load_i = 1'b0;
    logic        div_o, mod_ctl_o, cfg_valid_o, cfg_error_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pulse_swallow_divider u_pulse_swallow_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .pmode_i     (pmode_i),
        .b_i         (b_i),
        .a_i         (a_i),
        .load_i      (load_i),
        .div_o       (div_o),
        .mod_ctl_o   (mod_ctl_o),
        .cfg_valid_o (cfg_valid_o),
        .cfg_error_o (cfg_error_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pval(input int m);
        return (m == 0) ? 8 : (m == 1) ? 16 : (m == 2) ? 32 : 0;
    endfunction

    function automatic int legal(input int m, input int b, input int a);
        int p = pval(m);
        return (p != 0 && b >= 3 && a <= b && b * p + a >= p * p - p) ? 1 : 0;
    endfunction

    task automatic do_load(input int m, input int b, input int a);
        @(negedge clk);
        pmode_i = 2'(m);
        b_i     = 13'(b);
        a_i     = 5'(a);
        load_i  = 1'b1;
        @(negedge clk);
        load_i  = 1'b0;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!div_o);
    endtask

    // Called at a pulse sample; returns cycles to the next pulse and mod_ctl high time.
    task automatic measure(input int ld_at, input int m, input int b, input int a,
                           output int len, output int mch);
        len = 0;
        mch = mod_ctl_o ? 1 : 0;
        forever begin
            @(negedge clk);
            len = len + 1;
            if (len == ld_at) begin
                pmode_i = 2'(m);
                b_i     = 13'(b);
                a_i     = 5'(a);
                load_i  = 1'b1;
            end else begin
                load_i  = 1'b0;
            end
            if (div_o) break;
            if (mod_ctl_o) mch = mch + 1;
        end
        load_i = 1'b0;
    endtask

    task automatic run_cfg(input int m, input int b, input int a);
        int len, mch, p;
        p = pval(m);
        do_load(m, b, a);
        chk("R5/R6 cfg_error after legal load", int'(cfg_error_o), 0);
        wait_pulse();
        measure(-1, 0, 0, 0, len, mch);
        chk("R1 pulse spacing", len, b * p + a);
        chk("R3 mod_ctl high time", mch, a * (p + 1));
    endtask

    task automatic reject(input int m, input int b, input int a, input string req);
        do_load(m, b, a);
        chk(req, int'(cfg_error_o), 1);
    endtask

    initial begin
        int len, mch;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: idle after reset
        chk("R8 div_o at reset", int'(div_o), 0);
        chk("R8 mod_ctl_o at reset", int'(mod_ctl_o), 0);
        chk("R8 cfg_valid_o at reset", int'(cfg_valid_o), 0);
        chk("R8 cfg_error_o at reset", int'(cfg_error_o), 0);
        begin
            int seen = 0;
            repeat (200) begin
                @(negedge clk);
                if (div_o || mod_ctl_o) seen = seen + 1;
            end
            chk("R8 no activity before load", seen, 0);
        end

        // R6: first legal load starts the divider
        run_cfg(0, 10, 3);
        chk("R6 cfg_valid_o after first legal load", int'(cfg_valid_o), 1);

        // R4: the sample after a pulse is low
        @(negedge clk);
        chk("R4 pulse is one cycle", int'(div_o), 0);

        // R7: load mid-period keeps the current period
        wait_pulse();
        measure(20, 0, 12, 5, len, mch);
        chk("R7 period during load keeps old N", len, 83);
        measure(-1, 0, 0, 0, len, mch);
        chk("R7 next period uses new N", len, 101);
        chk("R7 next period mod_ctl", mch, 5 * 9);

        // R5 / R2: rejected words keep the running divisor
        reject(3, 20, 2, "R2 mode 2'b11 rejected");
        reject(0, 2, 0, "R5 B below 3 rejected");
        reject(0, 8, 9, "R5 A above B rejected");
        reject(0, 6, 7, "R5 A above B rejected");
        wait_pulse();
        measure(-1, 0, 0, 0, len, mch);
        chk("R5 divisor unchanged after rejects", len, 101);
        chk("R5 error flag still set", int'(cfg_error_o), 1);

        // R9: limit boundary at P=16 and P=32
        reject(1, 14, 14, "R9 N=238 below 240 rejected");
        run_cfg(1, 15, 0);
        chk("R6 legal load clears error", int'(cfg_error_o), 0);
        reject(2, 30, 30, "R9 N=990 below 992 rejected");
        run_cfg(2, 31, 0);
        run_cfg(2, 31, 31);
        run_cfg(2, 40, 7);
        run_cfg(1, 16, 1);
        run_cfg(1, 17, 15);
        run_cfg(1, 15, 15);

        // R1/R3/R5/R9: exhaustive sweep at P=8
        for (int b = 2; b <= 14; b++) begin
            for (int a = 0; a <= 31; a++) begin
                if (legal(0, b, a) != 0) run_cfg(0, b, a);
                else reject(0, b, a, "R5 sweep reject");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule